// File: doc/BRIEF.md
# Frame Sync Loss Monitor

This block checks that a serial port's frame sync keeps a fixed phase against a time base counted from the system clock. The time base advances on a strobe that pulses once for every half period of the bit clock, so phase is resolved in half-bit units. One frame spans `2*BITS_PER_FRAME` of those units.

When a frame sync edge lands outside a window of three half-bit units around its expected position, the block declares loss of synchronization. It also does this when no edge arrives by the end of that window. While synchronization is lost, it disables the serial data output driver and forces the converter path to mid-scale.

Once frame sync is steady again, the block keeps both forced states for a holdoff of 32 in-tolerance frames. It then releases them and marks the release with a one-cycle pulse. The first edge after reset only sets the reference phase. Any disturbance during the holdoff starts the holdoff again from zero.

Top module: `fsync_loss_monitor`

## Requirements
- R1: During and after synchronous reset, `sync_lost`=1, `dout_oe`=0, `dac_midscale`=1 and `resync_done`=0.
- R2: The first rising edge of `fsync` after reset sets the reference phase and does not release the outputs. Release needs 32 further in-tolerance edges.
- R3: Phase is counted in pulses of `half_en`, which comes once per bit-clock half period. A frame is 2*BITS_PER_FRAME pulses (128 by default). A rising edge of `fsync` is one sampled high after a sampled low.
- R4: While locked, an edge within ±3 half-bit units of the expected position leaves all outputs unchanged. The reference phase stays where it was.
- R5: An edge more than 3 half-bit units early or late sets `sync_lost` on the clock edge that samples it, and becomes the new reference phase.
- R6: If no edge arrives within the window, `sync_lost` is set on the clock edge where the phase reaches 4 units past the expected position. The reference phase is kept.
- R7: `dout_oe` is 0 and `dac_midscale` is 1 exactly while `sync_lost` is 1. Otherwise `dout_oe` is 1 and `dac_midscale` is 0.
- R8: On the 32nd consecutive in-tolerance edge since the last loss, `sync_lost` clears and `resync_done` is 1 for exactly one cycle.
- R9: A late, early or missing edge during the holdoff restarts the count of 32 from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_en | input | 1 | Strobe, one pulse per bit-clock half period |
| fsync | input | 1 | Frame sync, synchronous to clk |
| sync_lost | output | 1 | Loss-of-synchronization flag |
| dout_oe | output | 1 | Serial data output driver enable |
| dac_midscale | output | 1 | Force converter code to mid-scale |
| resync_done | output | 1 | One-cycle pulse when the holdoff completes |

## Verification
The hardest situation to reach is a disturbance partway through the holdoff. The stimulus has to place a missing or off-phase edge after a known number of clean frames and then show that release needs a full 32 more. The bench controls every gap between frame sync edges to the exact clock cycle, with the strobe held high, so each edge's phase follows from the sum of the gaps. A skipped edge is made by idling 131 and then 132 cycles past the last edge, which brackets the exact cycle the miss is declared. Tolerance limits are checked at +3, -3, +4 and -4 units.

// File: rtl/fslm_pkg.sv
package fslm_pkg;

    typedef enum logic [1:0] {
        LK_UNALIGNED,
        LK_HOLDOFF,
        LK_LOCKED
    } lock_state_e;

    // Classification of the current cycle's frame sync activity
    typedef struct packed {
        logic first;   // first edge after reset, sets the reference
        logic good;    // edge inside the tolerance window
        logic bad;     // edge outside the tolerance window
        logic miss;    // window passed with no edge
    } fs_event_t;

    // Distance of a phase sample from zero on a circular scale of span units
    function automatic int unsigned phase_offset(int unsigned p, int unsigned span);
        return (p < span / 2) ? p : span - p;
    endfunction

endpackage

// File: rtl/fslm_phase_tracker.sv
module fslm_phase_tracker
    import fslm_pkg::*;
#(
    parameter int unsigned FRAME_HALVES = 128,
    parameter int unsigned TOL_HALVES   = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      half_en,
    input  logic      fsync,
    output fs_event_t ev
);
    localparam int unsigned PW = $clog2(FRAME_HALVES);
    localparam logic [PW-1:0] LAST  = PW'(FRAME_HALVES - 1);
    localparam logic [PW-1:0] MID   = PW'(FRAME_HALVES / 2);
    localparam logic [PW-1:0] PROBE = PW'(TOL_HALVES + 1);

    logic [PW-1:0] phase_q, phase_d;
    logic          fs_q, aligned_q, hit_q;
    logic          edge_seen, off_lim, realign;

    always_comb begin
        edge_seen = fsync & ~fs_q;
        off_lim   = phase_offset(32'(phase_q), FRAME_HALVES) > TOL_HALVES;
        ev.first  = edge_seen & ~aligned_q;
        ev.good   = edge_seen & aligned_q & ~off_lim;
        ev.bad    = edge_seen & aligned_q & off_lim;
        ev.miss   = aligned_q & ~edge_seen & ~hit_q & (phase_q == PROBE);
        realign   = ev.first | ev.bad;
        // a realigning edge counts as phase zero, so the next tick reads one
        if (realign)
            phase_d = half_en ? PW'(1) : '0;
        else if (half_en)
            phase_d = (phase_q == LAST) ? '0 : phase_q + PW'(1);
        else
            phase_d = phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= '0;
            fs_q      <= 1'b0;
            aligned_q <= 1'b0;
            hit_q     <= 1'b0;
        end else begin
            phase_q <= phase_d;
            fs_q    <= fsync;
            if (edge_seen)
                aligned_q <= 1'b1;
            if (edge_seen || ev.miss)
                hit_q <= 1'b1;
            else if (phase_q == MID)
                hit_q <= 1'b0;
        end
    end

    // R6
    miss_once_chk: assert property (@(posedge clk) disable iff (rst)
        ev.miss |=> !ev.miss);

    // R5
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        ev.bad |=> (phase_q <= PW'(1)));

    // R3
    event_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.first, ev.good, ev.bad, ev.miss}));

endmodule

// File: rtl/fslm_lock_ctrl.sv
module fslm_lock_ctrl
    import fslm_pkg::*;
#(
    parameter int unsigned HOLD_FRAMES = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  fs_event_t ev,
    output logic      lost,
    output logic      done
);
    localparam int unsigned CW = $clog2(HOLD_FRAMES + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_FRAMES - 1);
    localparam logic [CW-1:0] HOLD_FULL = CW'(HOLD_FRAMES);

    lock_state_e   st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LK_UNALIGNED;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                LK_UNALIGNED: begin
                    if (ev.first) begin
                        st_q  <= LK_HOLDOFF;
                        cnt_q <= '0;
                    end
                end
                LK_HOLDOFF: begin
                    if (ev.bad || ev.miss) begin
                        cnt_q <= '0;
                    end else if (ev.good) begin
                        if (cnt_q == HOLD_LAST) begin
                            st_q  <= LK_LOCKED;
                            cnt_q <= HOLD_FULL;
                            done  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                LK_LOCKED: begin
                    if (ev.bad || ev.miss) begin
                        st_q  <= LK_HOLDOFF;
                        cnt_q <= '0;
                    end
                end
                default: begin
                    st_q  <= LK_UNALIGNED;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign lost = (st_q != LK_LOCKED);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (lost && !done));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lost) |-> done);

    // R5
    loss_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.bad || ev.miss) |=> lost);

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!lost && !ev.bad && !ev.miss) |=> !lost);

endmodule

// File: rtl/fsync_loss_monitor.sv
module fsync_loss_monitor
    import fslm_pkg::*;
#(
    parameter int unsigned BITS_PER_FRAME = 64,
    parameter int unsigned TOL_HALVES     = 3,
    parameter int unsigned HOLD_FRAMES    = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic half_en,
    input  logic fsync,
    output logic sync_lost,
    output logic dout_oe,
    output logic dac_midscale,
    output logic resync_done
);
    localparam int unsigned FRAME_HALVES = 2 * BITS_PER_FRAME;

    fs_event_t ev;
    logic      lost;

    fslm_phase_tracker #(
        .FRAME_HALVES (FRAME_HALVES),
        .TOL_HALVES   (TOL_HALVES)
    ) u_track (
        .clk     (clk),
        .rst     (rst),
        .half_en (half_en),
        .fsync   (fsync),
        .ev      (ev)
    );

    fslm_lock_ctrl #(
        .HOLD_FRAMES (HOLD_FRAMES)
    ) u_lock (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .lost (lost),
        .done (resync_done)
    );

    assign sync_lost    = lost;
    assign dout_oe      = ~lost;
    assign dac_midscale = lost;

    // R7
    force_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_lost) |-> (!dout_oe && dac_midscale));

endmodule

// File: tb/fsync_loss_monitor_test.sv
module fsync_loss_monitor_test;

    logic clk = 1'b0;
    logic rst, half_en, fsync;
    logic sync_lost, dout_oe, dac_midscale, resync_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    fsync_loss_monitor uut (
        .clk          (clk),
        .rst          (rst),
        .half_en      (half_en),
        .fsync        (fsync),
        .sync_lost    (sync_lost),
        .dout_oe      (dout_oe),
        .dac_midscale (dac_midscale),
        .resync_done  (resync_done)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // R7: forced states follow the lost flag
    task automatic chk_state(string tag, logic exp_lost, logic exp_done);
        chk(tag, "sync_lost", sync_lost, exp_lost);
        chk(tag, "dout_oe", dout_oe, ~exp_lost);
        chk(tag, "dac_midscale", dac_midscale, exp_lost);
        chk(tag, "resync_done", resync_done, exp_done);
    endtask

    // gap cycles after the previous edge, a one-cycle fsync high; sample after it
    task automatic frame(int gap);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            fsync = (i == gap - 1);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fsync = 1'b0;
            @(posedge clk);
            #1;
        end
    endtask

    // R8: 31 clean frames keep the outputs forced, the 32nd releases them
    task automatic release_seq(string tag);
        for (int i = 0; i < 31; i++) begin
            frame(128);
            chk_state({tag, " holdoff"}, 1'b1, 1'b0);
        end
        frame(128);
        chk_state("R8 release", 1'b0, 1'b1);
        idle(1);
        chk_state("R8 pulse end", 1'b0, 1'b0);
        frame(127);
        chk_state("R7 locked", 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        rst = 1'b1; half_en = 1'b1; fsync = 1'b0;
        repeat (4) @(negedge clk);
        chk_state("R1 in reset", 1'b1, 1'b0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk_state("R1 after reset", 1'b1, 1'b0);
    endtask

    task automatic t_acquire;
        frame(10);
        chk_state("R2 first edge", 1'b1, 1'b0);
        release_seq("R2");
    endtask

    task automatic t_tolerance;
        frame(131);
        chk_state("R4 late by 3", 1'b0, 1'b0);
        frame(125);
        chk_state("R4 back to 0", 1'b0, 1'b0);
        frame(125);
        chk_state("R4 early by 3", 1'b0, 1'b0);
        frame(131);
        chk_state("R4 back to 0", 1'b0, 1'b0);
    endtask

    task automatic t_late;
        frame(132);
        chk_state("R5 late by 4", 1'b1, 1'b0);
        release_seq("R5 late");
    endtask

    task automatic t_early;
        frame(124);
        chk_state("R5 early by 4", 1'b1, 1'b0);
        release_seq("R5 early");
    endtask

    task automatic t_missing;
        idle(131);
        chk_state("R6 window open", 1'b0, 1'b0);
        idle(1);
        chk_state("R6 missing edge", 1'b1, 1'b0);
        frame(124);
        chk_state("R6 kept reference", 1'b1, 1'b0);
    endtask

    task automatic t_restart;
        for (int i = 0; i < 9; i++) begin
            frame(128);
            chk_state("R9 partial holdoff", 1'b1, 1'b0);
        end
        frame(135);
        chk_state("R9 disturbed", 1'b1, 1'b0);
        release_seq("R9");
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL R8 watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_acquire();
        t_tolerance();
        t_late();
        t_early();
        t_missing();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule